// File: doc/BRIEF.md
# Two-Side Readout Token Sequencer

This block starts the readout of a double-sided strip detector module: one hybrid on the P side and one on the N side, each a serial chain of six front-end chips that pass a token along as they shift out their analog samples. On an accepted start request the P hybrid gets its token at once. The N hybrid gets its token a programmable number of readout clocks later. The block moves the analog multiplexer select from P to N on the edge that issues the N token. As a result, the two serial readouts follow each other on one shared differential line.

The delay is captured when the start is accepted, so it can be set to match a P chain that has been shortened by bypassing broken chips. The block watches the return token from each hybrid. If the P chain has not finished by the time the N token goes out, it sets a sticky sequencing-error flag. The sequence ends, and the select goes back to P, when the N return token arrives or when a fixed timeout expires. Error flags raised by either hybrid during a sequence are recorded but do not change its course.

Top module: `rdo_token_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all outputs are 0.
- R2: A start request sampled high while the block is idle makes `p_tok_o` high for exactly one cycle, namely the next cycle. `busy_o` rises in that same cycle.
- R3: `n_tok_o` is a single-cycle pulse issued max(D,1) cycles after the `p_tok_o` cycle. D is the value of `delay_i` sampled together with the accepted start; later changes to `delay_i` have no effect on the running sequence.
- R4: `mux_sel_o` (0 selects P, 1 selects N) rises in the cycle of `n_tok_o` and stays high until the sequence ends. It is never high while `busy_o` is low.
- R5: `seq_err_o` goes high in the `n_tok_o` cycle if `p_ret_i` was not sampled high in any cycle from the `p_tok_o` cycle up to the cycle before `n_tok_o`.
- R6: If `n_ret_i` is sampled high in any cycle from the `n_tok_o` cycle onward, the next cycle has `busy_o` and `mux_sel_o` low.
- R7: If `n_ret_i` stays low for TIMEOUT cycles, counted from the `n_tok_o` cycle, the sequence ends in the next cycle and `tmo_o` is set.
- R8: A start request while `busy_o` is high is ignored: no `p_tok_o` and no change to the sequence.
- R9: `p_err_i` or `n_err_i` sampled high while busy sets `p_err_o` or `n_err_o` respectively. The token and select timing is unaffected.
- R10: The sticky flags `seq_err_o`, `tmo_o`, `p_err_o` and `n_err_o` hold until an accepted start, which clears them in the `p_tok_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Readout start request |
| delay_i | input | DLY_W | N-token delay in readout clocks |
| p_ret_i | input | 1 | Return token from the P hybrid |
| n_ret_i | input | 1 | Return token from the N hybrid |
| p_err_i | input | 1 | Error flag from the P hybrid |
| n_err_i | input | 1 | Error flag from the N hybrid |
| p_tok_o | output | 1 | Token to the P hybrid |
| n_tok_o | output | 1 | Delayed token to the N hybrid |
| mux_sel_o | output | 1 | Analog line select, 1 = N side |
| busy_o | output | 1 | Sequence in progress |
| seq_err_o | output | 1 | Sticky: P chain not finished at N token |
| tmo_o | output | 1 | Sticky: N return token timed out |
| p_err_o | output | 1 | Sticky: P hybrid error seen |
| n_err_o | output | 1 | Sticky: N hybrid error seen |

## Verification
Several properties are checked on every cycle: both tokens are single-cycle pulses, the select rises exactly with the N token and is low whenever the block is idle, a P token never follows a busy cycle, and the sequencing error can only rise together with the N token. The actual delay length, the capture of the delay value at start, the end on return token versus on timeout, and the clearing of the sticky flags cannot be checked that way. Only the bench's scenarios show them, by comparing every output against a behavioural model driven with delays of 0, 1, small and large values, late or missing return tokens, and hybrid errors.

// File: rtl/rdo_seq_pkg.sv
package rdo_seq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PSIDE = 2'd1,
    PH_NSIDE = 2'd2
  } rdo_phase_e;
endpackage

// File: rtl/rdo_dly_cnt.sv
// Down-counter for the inter-side token delay; expire_o marks the last P cycle.
module rdo_dly_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         run_i,
  output logic         expire_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load_i) begin
      cnt <= val_i;
    end else if (run_i && cnt > W'(1)) begin
      cnt <= cnt - W'(1);
    end
  end

  assign expire_o = run_i && (cnt <= W'(1));
endmodule

// File: rtl/rdo_nside_timer.sv
// Counts cycles spent waiting for the N return token.
module rdo_nside_timer #(
  parameter int LIMIT = 4095,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic hit_o
);
  logic [W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      tmr <= '0;
    end else begin
      tmr <= tmr + W'(1);
    end
  end

  assign hit_o = run_i && (tmr == W'(LIMIT - 1));
endmodule

// File: rtl/rdo_status_latch.sv
// Sticky status flags; a clear has priority over every set.
module rdo_status_latch (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic busy_i,
  input  logic p_err_i,
  input  logic n_err_i,
  input  logic seq_set_i,
  input  logic tmo_set_i,
  output logic seq_err_o,
  output logic tmo_o,
  output logic p_err_o,
  output logic n_err_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      seq_err_o <= 1'b0;
      tmo_o     <= 1'b0;
      p_err_o   <= 1'b0;
      n_err_o   <= 1'b0;
    end else begin
      if (seq_set_i)          seq_err_o <= 1'b1;
      if (tmo_set_i)          tmo_o     <= 1'b1;
      if (busy_i && p_err_i)  p_err_o   <= 1'b1;
      if (busy_i && n_err_i)  n_err_o   <= 1'b1;
    end
  end
endmodule

// File: rtl/rdo_token_seq.sv
module rdo_token_seq #(
  parameter int DLY_W   = 12,
  parameter int TIMEOUT = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             p_ret_i,
  input  logic             n_ret_i,
  input  logic             p_err_i,
  input  logic             n_err_i,
  output logic             p_tok_o,
  output logic             n_tok_o,
  output logic             mux_sel_o,
  output logic             busy_o,
  output logic             seq_err_o,
  output logic             tmo_o,
  output logic             p_err_o,
  output logic             n_err_o
);
  import rdo_seq_pkg::*;

  rdo_phase_e ph;
  logic       p_done;
  logic       start_acc;
  logic       dly_expire;
  logic       tmo_hit;
  logic       seq_set;
  logic       tmo_set;

  assign start_acc = (ph == PH_IDLE) && start_i;
  assign seq_set   = (ph == PH_PSIDE) && dly_expire && !(p_done || p_ret_i);
  assign tmo_set   = (ph == PH_NSIDE) && !n_ret_i && tmo_hit;

  rdo_dly_cnt #(.W(DLY_W)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load_i   (start_acc),
    .val_i    (delay_i),
    .run_i    (ph == PH_PSIDE),
    .expire_o (dly_expire)
  );

  rdo_nside_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .run_i (ph == PH_NSIDE),
    .hit_o (tmo_hit)
  );

  rdo_status_latch u_stat (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (start_acc),
    .busy_i    (ph != PH_IDLE),
    .p_err_i   (p_err_i),
    .n_err_i   (n_err_i),
    .seq_set_i (seq_set),
    .tmo_set_i (tmo_set),
    .seq_err_o (seq_err_o),
    .tmo_o     (tmo_o),
    .p_err_o   (p_err_o),
    .n_err_o   (n_err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      p_tok_o   <= 1'b0;
      n_tok_o   <= 1'b0;
      mux_sel_o <= 1'b0;
      busy_o    <= 1'b0;
      p_done    <= 1'b0;
    end else begin
      p_tok_o <= 1'b0;
      n_tok_o <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start_i) begin
            ph      <= PH_PSIDE;
            p_tok_o <= 1'b1;
            busy_o  <= 1'b1;
            p_done  <= 1'b0;
          end
        end
        PH_PSIDE: begin
          if (p_ret_i) p_done <= 1'b1;
          if (dly_expire) begin
            ph        <= PH_NSIDE;
            n_tok_o   <= 1'b1;
            mux_sel_o <= 1'b1;
          end
        end
        PH_NSIDE: begin
          if (n_ret_i || tmo_hit) begin
            ph        <= PH_IDLE;
            mux_sel_o <= 1'b0;
            busy_o    <= 1'b0;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdo_token_seq_chk.sv
module rdo_token_seq_chk (
  input logic clk,
  input logic rst,
  input logic p_tok_o,
  input logic n_tok_o,
  input logic mux_sel_o,
  input logic busy_o,
  input logic seq_err_o
);
  a_r2_ptok_single: assert property (@(posedge clk) disable iff (rst)
    p_tok_o |=> !p_tok_o);
  a_r2_ptok_with_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> p_tok_o);
  a_r3_ntok_single: assert property (@(posedge clk) disable iff (rst)
    n_tok_o |=> !n_tok_o);
  a_r4_mux_with_ntok: assert property (@(posedge clk) disable iff (rst)
    n_tok_o |-> $rose(mux_sel_o));
  a_r4_mux_needs_busy: assert property (@(posedge clk) disable iff (rst)
    mux_sel_o |-> busy_o);
  a_r5_seqerr_at_ntok: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err_o) |-> n_tok_o);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    p_tok_o |-> !$past(busy_o));
endmodule

bind rdo_token_seq rdo_token_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .p_tok_o   (p_tok_o),
  .n_tok_o   (n_tok_o),
  .mux_sel_o (mux_sel_o),
  .busy_o    (busy_o),
  .seq_err_o (seq_err_o)
);

// File: tb/rdo_token_seq_bench.sv
module rdo_token_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DLY_W      = 12;
  localparam int TMO        = 4095;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [DLY_W-1:0] delay_i = '0;
  logic p_ret_i = 1'b0, n_ret_i = 1'b0, p_err_i = 1'b0, n_err_i = 1'b0;
  logic p_tok_o, n_tok_o, mux_sel_o, busy_o, seq_err_o, tmo_o, p_err_o, n_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdo_token_seq #(.DLY_W(DLY_W), .TIMEOUT(TMO)) u_rdo_token_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .delay_i(delay_i),
    .p_ret_i(p_ret_i), .n_ret_i(n_ret_i), .p_err_i(p_err_i), .n_err_i(n_err_i),
    .p_tok_o(p_tok_o), .n_tok_o(n_tok_o), .mux_sel_o(mux_sel_o), .busy_o(busy_o),
    .seq_err_o(seq_err_o), .tmo_o(tmo_o), .p_err_o(p_err_o), .n_err_o(n_err_o)
  );

  // Behavioural reference: phase 0 idle, 1 P readout, 2 N readout.
  int m_ph = 0, m_k = 0, m_d = 1;
  bit m_pd = 0;
  bit e_ptok = 0, e_ntok = 0, e_mux = 0, e_busy = 0;
  bit e_seq = 0, e_tmo = 0, e_perr = 0, e_nerr = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_k = 0; m_pd = 0;
      e_ptok = 0; e_ntok = 0; e_mux = 0; e_busy = 0;
      e_seq = 0; e_tmo = 0; e_perr = 0; e_nerr = 0;
    end else begin
      e_ptok = 0;
      e_ntok = 0;
      if (m_ph != 0) begin
        if (p_err_i) e_perr = 1;
        if (n_err_i) e_nerr = 1;
      end
      if (m_ph == 0) begin
        if (start_i) begin
          m_ph = 1; m_k = 0; m_pd = 0;
          m_d = (int'(delay_i) == 0) ? 1 : int'(delay_i);
          e_seq = 0; e_tmo = 0; e_perr = 0; e_nerr = 0;
          e_ptok = 1; e_busy = 1;
        end
      end else if (m_ph == 1) begin
        if (p_ret_i) m_pd = 1;
        if (m_k + 1 >= m_d) begin
          if (!m_pd) e_seq = 1;
          m_ph = 2; m_k = 0; e_ntok = 1; e_mux = 1;
        end else begin
          m_k++;
        end
      end else begin
        if (n_ret_i) begin
          m_ph = 0; e_mux = 0; e_busy = 0;
        end else if (m_k + 1 == TMO) begin
          m_ph = 0; e_mux = 0; e_busy = 0; e_tmo = 1;
        end else begin
          m_k++;
        end
      end
    end
  end

  task automatic cmp(input logic act, input bit exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      cmp(p_tok_o,   e_ptok, "R2 p_tok_o");
      cmp(n_tok_o,   e_ntok, "R3 n_tok_o");
      cmp(mux_sel_o, e_mux,  "R4 mux_sel_o");
      cmp(busy_o,    e_busy, "R6 busy_o");
      cmp(seq_err_o, e_seq,  "R5 seq_err_o");
      cmp(tmo_o,     e_tmo,  "R7 tmo_o");
      cmp(p_err_o,   e_perr, "R9 p_err_o");
      cmp(n_err_o,   e_nerr, "R9 n_err_o");
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Pulse start; returns in the cycle after the accepting edge.
  task automatic go(input int d);
    delay_i = DLY_W'(d);
    start_i = 1'b1;
    tick(1);
    start_i = 1'b0;
  endtask

  task automatic pulse_n_ret;
    n_ret_i = 1'b1; tick(1); n_ret_i = 1'b0;
  endtask

  task automatic summary;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 100000 && !done) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      summary();
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: all outputs low out of reset
    cmp(p_tok_o | n_tok_o | mux_sel_o | busy_o, 1'b0, "R1 control outputs after reset");
    cmp(seq_err_o | tmo_o | p_err_o | n_err_o, 1'b0, "R1 status after reset");

    // Normal run, D=5, P returns in time
    go(5);
    cmp(p_tok_o, 1'b1, "R2 p token in cycle after start");
    delay_i = 12'd40;                 // R3: change after start must not matter
    tick(2); p_ret_i = 1'b1; tick(1); p_ret_i = 1'b0;
    tick(2);                          // now in cycle 5
    cmp(n_tok_o, 1'b1, "R3 n token after 5 cycles");
    cmp(mux_sel_o, 1'b1, "R4 mux follows n token");
    cmp(seq_err_o, 1'b0, "R5 no error when P returned");
    start_i = 1'b1; tick(1); start_i = 1'b0;
    cmp(p_tok_o, 1'b0, "R8 start while busy ignored");
    tick(3); pulse_n_ret();
    cmp(busy_o | mux_sel_o, 1'b0, "R6 end on N return");
    tick(2);

    // D=0 behaves as 1, no P return -> sequencing error; hybrid errors
    go(0);
    p_err_i = 1'b1; tick(1); p_err_i = 1'b0;
    cmp(n_tok_o, 1'b1, "R3 zero delay acts as one");
    cmp(seq_err_o, 1'b1, "R5 error without P return");
    n_err_i = 1'b1; tick(1); n_err_i = 1'b0;
    cmp(mux_sel_o, 1'b1, "R9 errors do not abort");
    tick(2); pulse_n_ret();
    cmp(p_err_o & n_err_o, 1'b1, "R9 hybrid errors latched");
    tick(1);

    // D=1, errors from previous run cleared at start
    go(1);
    cmp(seq_err_o | p_err_o | n_err_o, 1'b0, "R10 sticky flags cleared by start");
    p_ret_i = 1'b1; tick(1); p_ret_i = 1'b0;
    cmp(seq_err_o, 1'b0, "R5 P return in last P cycle counts");
    pulse_n_ret();
    tick(1);

    // Long delay, P return late, then timeout on N
    go(300);
    tick(299);
    p_ret_i = 1'b1;
    cmp(n_tok_o, 1'b0, "R3 no n token before delay");
    tick(1); p_ret_i = 1'b0;
    cmp(n_tok_o, 1'b1, "R3 n token after 300 cycles");
    tick(TMO - 1);
    cmp(busy_o, 1'b1, "R7 still waiting before timeout");
    tick(1);
    cmp(busy_o | mux_sel_o, 1'b0, "R7 timeout ends sequence");
    cmp(tmo_o, 1'b1, "R7 timeout flag set");
    tick(2);
    cmp(tmo_o, 1'b1, "R10 timeout flag held while idle");

    go(2);
    cmp(tmo_o, 1'b0, "R10 timeout flag cleared by start");
    tick(4); pulse_n_ret();
    tick(3);
    summary();
  end
endmodule